// File: doc/BRIEF.md
# Receive Frame Ring Writer

This block takes a received Ethernet frame as a byte stream marked with start and end flags and decides whether to keep it. The decision uses the destination address of the frame: the block's own station address, the all-ones broadcast address, or a group address looked up in a 64-bit filter mask. The hash index for that lookup is computed outside the block and arrives with the first byte. A promiscuous setting accepts every frame. A kept frame is stored in a circular buffer in local byte-wide RAM. The buffer is divided into 256-byte pages and bounded by a start page and a stop page.

Each stored frame starts at the current page. A 4-byte header comes first, followed by the frame bytes, which wrap from the stop page back to the start page. The header holds a status byte, the page where the next frame will go, and the stored length. Short frames are padded with zeros up to 60 bytes. When the header is complete, the current page moves to the next page, the status is latched and a one-cycle done pulse is raised.

A frame is refused outright if the receiver is halted or the ring lacks room for a maximum frame. A refused frame is consumed from the stream and nothing is written to memory. The stream source must wait while `rx_busy` is high before starting the next frame.

Top module: `rx_ring_writer`

## Requirements
- R1: When a start byte arrives while idle and `stop_cmd` is 1, or the free space is below 1518 bytes, the frame is consumed with no memory write and no change to `cur_pg`, `rx_status` or `rx_done`. Free space in bytes is 256*(bnd−cur) if cur < bnd, else 256*((stop−start)−(cur−bnd)).
- R2: With `rx_cfg[4]` set, every frame of at least 6 bytes is accepted whatever its destination.
- R3: A destination of six 0xFF bytes is accepted (without R2) only when `rx_cfg[2]` is 1.
- R4: A destination whose first byte has bit 0 set, and which is not broadcast, is accepted (without R2) only when `rx_cfg[3]` is 1 and `mcast_filter[s_hash]` is 1. `s_hash` is sampled with the start byte.
- R5: A destination with first-byte bit 0 clear is accepted (without R2) only when all six bytes match `station_addr`. The first received byte is compared with `station_addr[7:0]`, the sixth with `station_addr[47:40]`.
- R6: A frame rejected by the filter, including any frame shorter than 6 bytes, leaves `cur_pg` and `rx_status` unchanged and raises no `rx_done`.
- R7: Frame byte k is written to address cur_pg*256+4+k. When the write address would reach stop*256, it wraps to start*256. No write falls outside [start*256, stop*256).
- R8: An accepted frame shorter than 60 bytes is stored with zero bytes up to a stored size of 60.
- R9: The header occupies cur_pg*256 + 0..3 and holds, in that order: the status byte, the next page, and the low and high bytes of length = stored size + 4.
- R10: Next page = cur + floor((length + 4 + 255) / 256). If the result is at or past stop, (stop − start) is subtracted from it.
- R11: The status byte is 0x01, or 0x21 when the first destination byte has bit 0 set.
- R12: When the header is finished, `cur_pg` becomes the next page, `rx_status` takes the status byte, and `rx_done` is high for exactly one cycle.
- R13: After reset, `cur_pg` and `rx_status` are 0, and `rx_done`, `rx_busy` and `mem_we` are 0.
- R14: A one-cycle `cur_pg_load` sets `cur_pg` to `cur_pg_in` on the following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stop_cmd | input | 1 | Receiver halted; new frames are refused |
| rx_cfg | input | 8 | Receive configuration: bit 2 broadcast, bit 3 group, bit 4 promiscuous |
| ring_start_pg | input | 8 | First page of the ring |
| ring_stop_pg | input | 8 | Page just past the ring |
| bnd_pg | input | 8 | Boundary page owned by the reader |
| station_addr | input | 48 | Station address, first wire byte in bits 7:0 |
| mcast_filter | input | 64 | Group address filter mask |
| cur_pg_load | input | 1 | Load strobe for the current page |
| cur_pg_in | input | 8 | Value loaded into the current page |
| s_valid | input | 1 | Stream byte valid |
| s_sof | input | 1 | First byte of frame |
| s_eof | input | 1 | Last byte of frame |
| s_data | input | 8 | Stream byte |
| s_hash | input | 6 | Group hash index, valid with the first byte |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | 16 | RAM byte address |
| mem_wdata | output | 8 | RAM write data |
| cur_pg | output | 8 | Current page pointer |
| rx_status | output | 8 | Status of the last stored frame |
| rx_done | output | 1 | One-cycle pulse when a frame is stored |
| rx_busy | output | 1 | Frame in progress; hold off the next start byte |

## Verification
The bench targets the page-count boundary of the next-page formula: stored sizes of 248 and 249 bytes, where an off-by-one design moves the pointer one page too few or too many. It runs a frame that crosses the stop page, where a design with a wrong wrap would write past the ring or resume at the wrong address. It sets the boundary five and six pages ahead to probe the free-space threshold, where a wrong compare either overruns unread frames or refuses a frame that fits. It also sends short and sub-address-length frames, a broadcast without its enable, a group frame whose filter bit is clear, and a station address that differs only in the last byte. A design with faulty padding, filtering or pointer updates would store stale bytes, accept such frames or advance the pointer on a rejected frame.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_DROP,
    ST_PAD,
    ST_HDR
  } rxr_state_e;

  localparam int HDR_BYTES   = 4;
  localparam int CRC_BYTES   = 4;
  localparam int ADDR_BYTES  = 6;
  localparam int PAGE_BYTES  = 256;
  localparam int CFG_BCAST   = 2;
  localparam int CFG_GROUP   = 3;
  localparam int CFG_PROMISC = 4;
  localparam logic [7:0] STAT_OK    = 8'h01;
  localparam logic [7:0] STAT_GROUP = 8'h20;

  // bytes the writer may still fill before reaching the reader's boundary
  function automatic int ring_free_bytes(int cur, int bnd, int first, int last);
    if (cur < bnd) return (bnd - cur) * PAGE_BYTES;
    return ((last - first) - (cur - bnd)) * PAGE_BYTES;
  endfunction

  // page that follows a stored frame of 'size' bytes (header excluded)
  function automatic int next_page(int cur, int first, int last, int size);
    int total;
    int nxt;
    total = size + HDR_BYTES;
    nxt   = cur + ((total + CRC_BYTES + PAGE_BYTES - 1) / PAGE_BYTES);
    if (nxt >= last) nxt = nxt - (last - first);
    return nxt;
  endfunction

endpackage

// File: rtl/rxr_ring_space.sv
module rxr_ring_space
  import rxr_pkg::*;
#(
  parameter int PAGE_W    = 8,
  parameter int SPACE_MIN = 1518
) (
  input  logic [PAGE_W-1:0] cur,
  input  logic [PAGE_W-1:0] bnd,
  input  logic [PAGE_W-1:0] first_pg,
  input  logic [PAGE_W-1:0] last_pg,
  output logic              room_ok
);
  int free_b;

  always_comb begin
    free_b  = ring_free_bytes(int'(cur), int'(bnd), int'(first_pg), int'(last_pg));
    room_ok = (free_b >= SPACE_MIN);
  end
endmodule

// File: rtl/rxr_dest_filter.sv
module rxr_dest_filter
  import rxr_pkg::*;
#(
  parameter int HASH_W = 6,
  localparam int MASK_W = 1 << HASH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              first,
  input  logic              step,
  input  logic [7:0]        data,
  input  logic [47:0]       station,
  input  logic [7:0]        cfg,
  input  logic [MASK_W-1:0] mfilt,
  input  logic [HASH_W-1:0] hash,
  output logic              accept,
  output logic              group
);
  logic              uc_q, bc_q, grp_q;
  logic [2:0]        nb_q;
  logic [HASH_W-1:0] hash_q;
  logic              uc_n, bc_n, grp_n, in_dst;
  logic [2:0]        nb_n, idx, sel;
  logic [HASH_W-1:0] hash_n;
  logic [7:0]        sta_byte;

  always_comb begin
    idx      = first ? 3'd0 : nb_q;
    in_dst   = idx < 3'(ADDR_BYTES);
    sel      = in_dst ? idx : 3'd0;
    sta_byte = station[sel*8 +: 8];
    uc_n     = (first | uc_q) & (!in_dst | (data == sta_byte));
    bc_n     = (first | bc_q) & (!in_dst | (data == 8'hFF));
    grp_n    = first ? data[0] : grp_q;
    nb_n     = first ? 3'd1 : (in_dst ? nb_q + 3'd1 : nb_q);
    hash_n   = first ? hash : hash_q;
    group    = grp_n;
    accept   = (nb_n == 3'(ADDR_BYTES)) &
               (cfg[CFG_PROMISC] |
                (bc_n  ? cfg[CFG_BCAST] :
                 grp_n ? (cfg[CFG_GROUP] & mfilt[hash_n]) : uc_n));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      uc_q   <= 1'b0;
      bc_q   <= 1'b0;
      grp_q  <= 1'b0;
      nb_q   <= 3'd0;
      hash_q <= '0;
    end else if (step) begin
      uc_q   <= uc_n;
      bc_q   <= bc_n;
      grp_q  <= grp_n;
      nb_q   <= nb_n;
      hash_q <= hash_n;
    end
  end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rxr_pkg::*;
#(
  parameter int PAGE_W    = 8,
  parameter int HASH_W    = 6,
  parameter int LEN_W     = 16,
  parameter int MIN_FRAME = 60,
  parameter int MAX_FRAME = 1514,
  localparam int ADDR_W   = PAGE_W + 8,
  localparam int MASK_W   = 1 << HASH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_cmd,
  input  logic [7:0]        rx_cfg,
  input  logic [PAGE_W-1:0] ring_start_pg,
  input  logic [PAGE_W-1:0] ring_stop_pg,
  input  logic [PAGE_W-1:0] bnd_pg,
  input  logic [47:0]       station_addr,
  input  logic [MASK_W-1:0] mcast_filter,
  input  logic              cur_pg_load,
  input  logic [PAGE_W-1:0] cur_pg_in,
  input  logic              s_valid,
  input  logic              s_sof,
  input  logic              s_eof,
  input  logic [7:0]        s_data,
  input  logic [HASH_W-1:0] s_hash,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic [PAGE_W-1:0] cur_pg,
  output logic [7:0]        rx_status,
  output logic              rx_done,
  output logic              rx_busy
);
  localparam int SPACE_MIN = MAX_FRAME + HDR_BYTES;

  rxr_state_e        state;
  logic [ADDR_W-1:0] waddr, wr_addr, wr_next, ring_base, ring_end;
  logic [LEN_W-1:0]  cnt, fin_cnt, stored_len;
  logic [PAGE_W-1:0] frame_pg, cur_q, nxt_pg;
  logic [7:0]        stat_q, status_q;
  logic [1:0]        hi;
  logic              we_q, done_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wdata_q;

  // named internal events
  logic room_ok, admit, first_byte, data_byte, filt_step, filt_accept, filt_group;

  assign ring_base  = {ring_start_pg, 8'h00};
  assign ring_end   = {ring_stop_pg, 8'h00};
  assign admit      = room_ok & !stop_cmd;
  assign first_byte = (state == ST_IDLE) & s_valid & s_sof & admit;
  assign data_byte  = (state == ST_DATA) & s_valid;
  assign filt_step  = first_byte | data_byte;
  assign wr_addr    = (state == ST_IDLE) ? {cur_q, 8'(HDR_BYTES)} : waddr;
  assign wr_next    = (wr_addr + 1'b1 == ring_end) ? ring_base : wr_addr + 1'b1;
  assign fin_cnt    = first_byte ? LEN_W'(1) : cnt + 1'b1;
  assign stored_len = cnt + LEN_W'(HDR_BYTES);
  assign nxt_pg     = PAGE_W'(next_page(int'(frame_pg), int'(ring_start_pg),
                                        int'(ring_stop_pg), int'(cnt)));

  rxr_ring_space #(.PAGE_W(PAGE_W), .SPACE_MIN(SPACE_MIN)) u_space (
    .cur      (cur_q),
    .bnd      (bnd_pg),
    .first_pg (ring_start_pg),
    .last_pg  (ring_stop_pg),
    .room_ok  (room_ok)
  );

  rxr_dest_filter #(.HASH_W(HASH_W)) u_filt (
    .clk     (clk),
    .rst_n   (rst_n),
    .first   (first_byte),
    .step    (filt_step),
    .data    (s_data),
    .station (station_addr),
    .cfg     (rx_cfg),
    .mfilt   (mcast_filter),
    .hash    (s_hash),
    .accept  (filt_accept),
    .group   (filt_group)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      waddr    <= '0;
      cnt      <= '0;
      frame_pg <= '0;
      cur_q    <= '0;
      stat_q   <= '0;
      status_q <= '0;
      hi       <= '0;
      we_q     <= 1'b0;
      done_q   <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
    end else begin
      we_q   <= 1'b0;
      done_q <= 1'b0;
      if (cur_pg_load) cur_q <= cur_pg_in;
      case (state)
        ST_IDLE, ST_DATA: begin
          if (state == ST_IDLE && s_valid && s_sof && !admit) begin
            state <= s_eof ? ST_IDLE : ST_DROP;
          end else if (filt_step) begin
            if (first_byte) frame_pg <= cur_q;
            we_q    <= 1'b1;
            addr_q  <= wr_addr;
            wdata_q <= s_data;
            waddr   <= wr_next;
            cnt     <= fin_cnt;
            if (s_eof) begin
              hi <= '0;
              if (filt_accept) begin
                stat_q <= STAT_OK | (filt_group ? STAT_GROUP : 8'h00);
                state  <= (fin_cnt < LEN_W'(MIN_FRAME)) ? ST_PAD : ST_HDR;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              state <= ST_DATA;
            end
          end
        end
        ST_DROP: if (s_valid && s_eof) state <= ST_IDLE;
        ST_PAD: begin
          we_q    <= 1'b1;
          addr_q  <= waddr;
          wdata_q <= 8'h00;
          waddr   <= wr_next;
          cnt     <= cnt + 1'b1;
          if (cnt + 1'b1 == LEN_W'(MIN_FRAME)) state <= ST_HDR;
        end
        ST_HDR: begin
          we_q   <= 1'b1;
          addr_q <= {frame_pg, 6'b0, hi};
          case (hi)
            2'd0:    wdata_q <= stat_q;
            2'd1:    wdata_q <= 8'(nxt_pg);
            2'd2:    wdata_q <= stored_len[7:0];
            default: wdata_q <= stored_len[15:8];
          endcase
          if (hi == 2'd3) begin
            cur_q    <= nxt_pg;
            status_q <= stat_q;
            done_q   <= 1'b1;
            state    <= ST_IDLE;
          end else begin
            hi <= hi + 2'd1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign cur_pg    = cur_q;
  assign rx_status = status_q;
  assign rx_done   = done_q;
  assign rx_busy   = (state != ST_IDLE);
endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk #(
  parameter int PAGE_W = 8,
  localparam int ADDR_W = PAGE_W + 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stop_cmd,
  input logic              s_valid,
  input logic              s_sof,
  input logic              rx_busy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [PAGE_W-1:0] ring_start_pg,
  input logic [PAGE_W-1:0] ring_stop_pg,
  input logic              rx_done,
  input logic [7:0]        rx_status,
  input logic [PAGE_W-1:0] cur_pg,
  input logic              cur_pg_load
);
  p_refuse_stop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_busy && s_valid && s_sof && stop_cmd) |=> !mem_we);

  p_ring_bounds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr >= {ring_start_pg, 8'h00}) && (mem_addr < {ring_stop_pg, 8'h00}));

  p_status_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> rx_status[0] && ((rx_status & 8'hDE) == 8'h00));

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);

  p_status_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_done |-> $stable(rx_status));

  p_curpg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_done && !$past(cur_pg_load)) |-> $stable(cur_pg));
endmodule

bind rx_ring_writer rx_ring_writer_chk #(.PAGE_W(PAGE_W)) u_chk (.*);

// File: tb/sim_rx_ring_writer.sv
module sim_rx_ring_writer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stop_cmd = 1'b0;
  logic [7:0]  rx_cfg = 8'h00;
  logic [7:0]  ring_start_pg = 8'd2;
  logic [7:0]  ring_stop_pg = 8'd12;
  logic [7:0]  bnd_pg = 8'd2;
  logic [47:0] station_addr = 48'hBC9A_7856_3412;
  logic [63:0] mcast_filter = 64'h0000_0000_0000_0200;
  logic        cur_pg_load = 1'b0;
  logic [7:0]  cur_pg_in = 8'd0;
  logic        s_valid = 1'b0, s_sof = 1'b0, s_eof = 1'b0;
  logic [7:0]  s_data = 8'h00;
  logic [5:0]  s_hash = 6'd0;
  logic        mem_we, rx_done, rx_busy;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, cur_pg, rx_status;

  always #4 clk = ~clk;

  rx_ring_writer u0 (.*);

  logic [7:0] bmem [4096];
  int wr_cnt = 0, done_cnt = 0, checks = 0, fails = 0, cyc = 0;
  bit ended = 0;
  int exp_cur = 0;
  logic [7:0] exp_stat = 8'h00;

  always @(posedge clk) begin
    if (rst_n && mem_we) begin
      bmem[mem_addr[11:0]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (rst_n && rx_done) done_cnt <= done_cnt + 1;
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
      finish_run();
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] fbyte(int kind, int i);
    if (i < 6) begin
      case (kind)
        0: return station_addr[i*8 +: 8];
        1: return (i == 5) ? (station_addr[i*8 +: 8] ^ 8'h01) : station_addr[i*8 +: 8];
        2: return 8'hFF;
        default: return (i == 0) ? 8'h01 : 8'(8'h10 + i);
      endcase
    end
    return 8'(i) ^ 8'h5A;
  endfunction

  function automatic int model_next(int cur, int size);
    int nx;
    nx = cur + (size + 8 + 255) / 256;
    if (nx >= int'(ring_stop_pg)) nx -= int'(ring_stop_pg) - int'(ring_start_pg);
    return nx;
  endfunction

  task automatic send_frame(int kind, int len, int hash);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      s_valid = 1'b1; s_sof = (i == 0); s_eof = (i == len - 1);
      s_data = fbyte(kind, i); s_hash = 6'(hash);
    end
    @(negedge clk);
    s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0;
    for (int w = 0; w < 3000 && rx_busy; w++) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_vec(int kind, int len, logic [7:0] cfg, int hash, bit acc, int bnd, string tag);
    int d0, base, size, nx;
    rx_cfg = cfg; bnd_pg = 8'(bnd);
    d0 = done_cnt; base = exp_cur * 256;
    send_frame(kind, len, hash);
    if (acc) begin
      size = (len < 60) ? 60 : len;
      nx = model_next(exp_cur, size);
      exp_stat = (kind >= 2) ? 8'h21 : 8'h01;
      check(done_cnt == d0 + 1, {tag, " R12 done"}, done_cnt - d0, 1);
      check(cur_pg == 8'(nx), {tag, " R10 next page"}, cur_pg, nx);
      check(rx_status == exp_stat, {tag, " R11 status"}, rx_status, exp_stat);
      check(bmem[base] == exp_stat, {tag, " R9 hdr status"}, bmem[base], exp_stat);
      check(bmem[base+1] == 8'(nx), {tag, " R9 hdr next"}, bmem[base+1], nx);
      check({bmem[base+3], bmem[base+2]} == 16'(size + 4), {tag, " R9 hdr len"},
            {bmem[base+3], bmem[base+2]}, size + 4);
      check(bmem[base+4] == fbyte(kind, 0), {tag, " R7 first byte"}, bmem[base+4], fbyte(kind, 0));
      if (len < 60) begin
        check(bmem[base+4+len] == 8'h00, {tag, " R8 pad start"}, bmem[base+4+len], 0);
        check(bmem[base+4+59] == 8'h00, {tag, " R8 pad end"}, bmem[base+4+59], 0);
      end
      exp_cur = nx;
    end else begin
      check(done_cnt == d0, {tag, " R6 no done"}, done_cnt - d0, 0);
      check(cur_pg == 8'(exp_cur), {tag, " R6 page kept"}, cur_pg, exp_cur);
      check(rx_status == exp_stat, {tag, " R6 status kept"}, rx_status, exp_stat);
    end
  endtask

  typedef struct packed {
    logic [1:0]  kind;
    logic [15:0] len;
    logic [7:0]  cfg;
    logic [5:0]  hash;
    logic        acc;
  } vec_t;

  localparam vec_t VECS [13] = '{
    '{2'd0, 16'd64,  8'h00, 6'd0,  1'b1},  // R5 station match
    '{2'd1, 16'd64,  8'h00, 6'd0,  1'b0},  // R5 last byte differs
    '{2'd1, 16'd64,  8'h10, 6'd0,  1'b1},  // R2 promiscuous
    '{2'd2, 16'd64,  8'h00, 6'd0,  1'b0},  // R3 broadcast disabled
    '{2'd2, 16'd64,  8'h04, 6'd0,  1'b1},  // R3 broadcast enabled
    '{2'd3, 16'd64,  8'h08, 6'd9,  1'b1},  // R4 filter bit set
    '{2'd3, 16'd64,  8'h08, 6'd10, 1'b0},  // R4 filter bit clear
    '{2'd3, 16'd64,  8'h04, 6'd9,  1'b0},  // R4 group disabled
    '{2'd0, 16'd20,  8'h00, 6'd0,  1'b1},  // R8 padding
    '{2'd0, 16'd3,   8'h10, 6'd0,  1'b0},  // R6 shorter than address
    '{2'd0, 16'd300, 8'h00, 6'd0,  1'b1},  // R10 two pages
    '{2'd0, 16'd248, 8'h00, 6'd0,  1'b1},  // R10 exactly one page
    '{2'd0, 16'd249, 8'h00, 6'd0,  1'b1}   // R10 one byte over
  };

  initial begin
    int w0, d0;
    for (int i = 0; i < 4096; i++) bmem[i] = 8'hEE;
    repeat (4) @(negedge clk);
    // R13 reset state
    check(cur_pg == 8'd0, "R13 cur_pg", cur_pg, 0);
    check(rx_status == 8'd0, "R13 status", rx_status, 0);
    check(!rx_done && !rx_busy && !mem_we, "R13 outputs idle",
          {rx_done, rx_busy, mem_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R14 pointer load
    cur_pg_in = 8'd2; cur_pg_load = 1'b1;
    @(negedge clk);
    cur_pg_load = 1'b0;
    check(cur_pg == 8'd2, "R14 load", cur_pg, 2);
    exp_cur = 2;

    for (int v = 0; v < 13; v++)
      run_vec(int'(VECS[v].kind), int'(VECS[v].len), VECS[v].cfg, int'(VECS[v].hash),
              VECS[v].acc, exp_cur, $sformatf("vec%0d", v));

    // R1 halted receiver
    cur_pg_in = 8'd4; cur_pg_load = 1'b1;
    @(negedge clk);
    cur_pg_load = 1'b0;
    exp_cur = 4;
    check(cur_pg == 8'd4, "R14 reload", cur_pg, 4);
    stop_cmd = 1'b1; w0 = wr_cnt; d0 = done_cnt;
    rx_cfg = 8'h10; bnd_pg = 8'd4;
    send_frame(0, 64, 0);
    check(wr_cnt == w0, "R1 stop no writes", wr_cnt - w0, 0);
    check(done_cnt == d0 && cur_pg == 8'd4, "R1 stop no update", cur_pg, 4);
    stop_cmd = 1'b0;

    // R1 five free pages: refused
    w0 = wr_cnt; bnd_pg = 8'd9;
    send_frame(0, 64, 0);
    check(wr_cnt == w0, "R1 full no writes", wr_cnt - w0, 0);
    check(cur_pg == 8'd4, "R1 full page kept", cur_pg, 4);

    // R1 six free pages: accepted
    run_vec(0, 64, 8'h00, 0, 1'b1, 10, "R1 room");

    // R7 wrap across stop page
    cur_pg_in = 8'd10; cur_pg_load = 1'b1;
    @(negedge clk);
    cur_pg_load = 1'b0;
    exp_cur = 10;
    run_vec(0, 600, 8'h00, 0, 1'b1, 10, "R7 wrap");
    check(bmem[12'hBFF] == fbyte(0, 507), "R7 last before stop", bmem[12'hBFF], fbyte(0, 507));
    check(bmem[12'h200] == fbyte(0, 508), "R7 first after wrap", bmem[12'h200], fbyte(0, 508));
    check(cur_pg == 8'd3, "R10 wrapped next page", cur_pg, 3);

    finish_run();
  end
endmodule